// File: doc/BRIEF.md
# Picture-Memory Bank Mapper

This block is the part of a cartridge mapper that turns the picture processor's upper address lines into a bank number and a choice of memory. A CPU-side write port fills eight 8-bit bank registers and one 8-bit control byte. The control byte sets four things. It selects one of four layouts that spread the eight registers over twelve 1 KiB windows. It picks ROM or the console's internal nametable RAM for the nametable windows. It can replace the bank LSB with a picture address line so that one register serves a 2 KiB region. It also opens the CPU work-RAM window at $6000-$7FFF.

The picture side presents A13..A10. The block returns the bank number, a ROM enable, an internal-RAM enable and the A10 line for that RAM. Every output on this side is combinational from the stored registers and the present address, so it settles in the same cycle. The write port is valid/ready. Ready is held high, so a write is accepted on every clock edge where valid is high and the port never applies back-pressure. An accepted write becomes visible on the outputs from the next cycle onward.

Top module: `ppu_bank_mapper`

## Requirements
- R1: After reset all registers are zero. Window 0 then gives bank 0 from ROM, window 8 gives bank 0 from internal RAM, and the work-RAM enable is low.
- R2: An accepted write to $D000-$D003 loads bank registers B0-B3, a write to $E000-$E003 loads B4-B7, and a write to $B003 loads the control byte. A write to any other address changes no output. `wr_ready` is always high.
- R3: With control bits 1:0 = 00, pattern windows 0-7 use B0-B7 in order. With control bit 2 clear the nametable windows 8-11 use B6,B6,B7,B7, and with bit 2 set they use B6,B7,B6,B7.
- R4: With control bits 1:0 = 01, pattern window w uses register B(w/2). Nametable windows 8-11 use B4,B5,B6,B7 whatever bit 2 is.
- R5: With control bit 1 set, windows 0-3 use B0-B3, windows 4-5 use B4 and windows 6-7 use B5. The nametables are B6,B7,B6,B7 with bit 2 clear and B6,B6,B7,B7 with bit 2 set.
- R6: Pattern windows always assert `rom_en`. Nametable windows assert `rom_en` when control bit 4 is 1 and `ciram_en` when it is 0. Exactly one of the two is high at all times.
- R7: While `ciram_en` is high, `ciram_a10` equals bit 0 of the bank number. While `ciram_en` is low, `ciram_a10` is 0.
- R8: With control bit 5 set, a pattern window served by a 2 KiB bank has its bank LSB replaced by A10. That is every pattern window in layout 01 and windows 4-7 when bit 1 is set. All other pattern windows keep the register LSB.
- R9: With control bit 5 set, the nametable bank LSB depends on control bits 3:0. For 0 or 7 it is A10, for 3 or 4 it is A11, for 8 or 15 it is 0, and for 11 or 12 it is 1. Any other value keeps the register LSB. With bit 5 clear the register LSB is always kept.
- R10: Picture addresses with A13 and A12 both set (the $3000-$3FFF range) give the same outputs as the same A11..A10 with A12 clear.
- R11: `prg_ram_en` is high only when control bit 7 is set and `cpu_addr` lies in $6000-$7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request from the CPU side |
| wr_ready | output | 1 | Write acceptance, held high |
| cpu_addr | input | 16 | CPU address, used to decode writes and the work-RAM window |
| wr_data | input | 8 | Write data |
| ppu_a_hi | input | 4 | Picture address lines A13..A10 |
| chr_bank | output | 8 | Bank number for the current window |
| rom_en | output | 1 | Picture ROM enable |
| ciram_en | output | 1 | Internal nametable RAM enable |
| ciram_a10 | output | 1 | A10 line for the internal RAM |
| prg_ram_en | output | 1 | Work-RAM enable |

## Verification
The bench loads each register with a value that has a distinct LSB pattern. It then sweeps all twelve windows across control values that cover each layout, both nametable orders, both nametable sources and every LSB-override case. Each of these faults changes at least one expected byte and is caught:
- The 2 KiB layouts are mixed up.
- The meaning of bit 2 is swapped between layouts.
- The A10 substitution leaks into a 1 KiB window.
- The 0/7, 3/4, 8/15 and 11/12 override pairs are confused.

Writes to near-miss addresses are checked to leave the outputs untouched. The $3xxx mirror and the edges of the work-RAM window are also probed. A design that decoded only part of the address, or that let A12 select a pattern window above $2FFF, would fail these checks.

// File: rtl/ppu_bank_pkg.sv
package ppu_bank_pkg;

  localparam int NUM_BANK_REGS = 8;
  localparam int SEL_W         = $clog2(NUM_BANK_REGS);
  localparam int NUM_WIN       = 12;
  localparam int WIN_W         = $clog2(NUM_WIN);

  typedef enum logic [1:0] {
    MAP_1K    = 2'd0,
    MAP_2K    = 2'd1,
    MAP_MIX_A = 2'd2,
    MAP_MIX_B = 2'd3
  } map_mode_e;

  // bit order matters: the nametable override decodes bits 3:0 as one value
  typedef struct packed {
    logic      prg_ram_on;  // 7
    logic      spare;       // 6
    logic      lsb_sub;     // 5
    logic      nt_rom;      // 4
    logic      arr_hi;      // 3
    logic      arr_lo;      // 2
    map_mode_e mode;        // 1:0
  } ctrl_t;

  typedef enum logic [2:0] {
    LSB_KEEP = 3'd0,
    LSB_A10  = 3'd1,
    LSB_A11  = 3'd2,
    LSB_ZERO = 3'd3,
    LSB_ONE  = 3'd4
  } lsb_src_e;

endpackage

// File: rtl/ppu_bank_regfile.sv
module ppu_bank_regfile
  import ppu_bank_pkg::*;
#(
  parameter int                CPU_AW       = 16,
  parameter int                BANK_W       = 8,
  parameter logic [CPU_AW-1:0] BANK_LO_BASE = 16'hD000,
  parameter logic [CPU_AW-1:0] BANK_HI_BASE = 16'hE000,
  parameter logic [CPU_AW-1:0] CTRL_ADDR    = 16'hB003
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_fire,
  input  logic [CPU_AW-1:0]                     cpu_addr,
  input  logic [BANK_W-1:0]                     wr_data,
  output logic [NUM_BANK_REGS-1:0][BANK_W-1:0]  bank_q,
  output ctrl_t                                 ctrl_q
);

  localparam int HALF = NUM_BANK_REGS / 2;

  for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : g_bank
    localparam logic [CPU_AW-1:0] BASE = (g < HALF) ? BANK_LO_BASE : BANK_HI_BASE;
    localparam logic [CPU_AW-1:0] ADDR = BASE + CPU_AW'(g % HALF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (wr_fire && cpu_addr == ADDR) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_fire && cpu_addr == CTRL_ADDR) begin
      ctrl_q <= ctrl_t'(wr_data[7:0]);
    end
  end

endmodule

// File: rtl/ppu_win_router.sv
module ppu_win_router
  import ppu_bank_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  map_mode_e        mode,
  input  logic             arr_lo,
  output logic [SEL_W-1:0] sel,
  output logic             dbl,
  output logic             is_nt
);

  always_comb begin
    is_nt = win[3];
    sel   = '0;
    dbl   = 1'b0;
    if (!win[3]) begin
      unique case (mode)
        MAP_1K: sel = win[2:0];
        MAP_2K: begin
          sel = {1'b0, win[2:1]};
          dbl = 1'b1;
        end
        default: begin
          if (!win[2]) begin
            sel = win[2:0];
          end else begin
            sel = win[1] ? 3'd5 : 3'd4;
            dbl = 1'b1;
          end
        end
      endcase
    end else begin
      unique case (mode)
        MAP_1K:  sel = {2'b11, (arr_lo ? win[0] : win[1])};
        MAP_2K:  sel = {1'b1, win[1:0]};
        default: sel = {2'b11, (arr_lo ? win[1] : win[0])};
      endcase
    end
  end

endmodule

// File: rtl/ppu_lsb_patch.sv
module ppu_lsb_patch
  import ppu_bank_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  is_nt,
  input  logic  dbl,
  input  logic  a10,
  input  logic  a11,
  input  logic  reg_lsb,
  output logic  lsb
);

  lsb_src_e src;
  logic [3:0] nt_code;

  assign nt_code = {ctrl.arr_hi, ctrl.arr_lo, ctrl.mode};

  always_comb begin
    src = LSB_KEEP;
    if (ctrl.lsb_sub) begin
      if (!is_nt) begin
        src = dbl ? LSB_A10 : LSB_KEEP;
      end else begin
        case (nt_code)
          4'd0, 4'd7:   src = LSB_A10;
          4'd3, 4'd4:   src = LSB_A11;
          4'd8, 4'd15:  src = LSB_ZERO;
          4'd11, 4'd12: src = LSB_ONE;
          default:      src = LSB_KEEP;
        endcase
      end
    end
  end

  always_comb begin
    unique case (src)
      LSB_A10:  lsb = a10;
      LSB_A11:  lsb = a11;
      LSB_ZERO: lsb = 1'b0;
      LSB_ONE:  lsb = 1'b1;
      default:  lsb = reg_lsb;
    endcase
  end

endmodule

// File: rtl/ppu_bank_mapper.sv
module ppu_bank_mapper
  import ppu_bank_pkg::*;
#(
  parameter int                CPU_AW       = 16,
  parameter int                BANK_W       = 8,
  parameter logic [CPU_AW-1:0] BANK_LO_BASE = 16'hD000,
  parameter logic [CPU_AW-1:0] BANK_HI_BASE = 16'hE000,
  parameter logic [CPU_AW-1:0] CTRL_ADDR    = 16'hB003,
  parameter logic [2:0]        PRG_WIN_TAG  = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [3:0]        ppu_a_hi,
  output logic [BANK_W-1:0] chr_bank,
  output logic              rom_en,
  output logic              ciram_en,
  output logic              ciram_a10,
  output logic              prg_ram_en
);

  logic                                 wr_fire;
  logic [NUM_BANK_REGS-1:0][BANK_W-1:0] bank_q;
  ctrl_t                                ctrl_q;
  logic [WIN_W-1:0]                     win;
  logic [SEL_W-1:0]                     sel;
  logic                                 dbl;
  logic                                 is_nt;
  logic [BANK_W-1:0]                    bank_raw;
  logic                                 lsb;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  ppu_bank_regfile #(
    .CPU_AW      (CPU_AW),
    .BANK_W      (BANK_W),
    .BANK_LO_BASE(BANK_LO_BASE),
    .BANK_HI_BASE(BANK_HI_BASE),
    .CTRL_ADDR   (CTRL_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .cpu_addr(cpu_addr),
    .wr_data (wr_data),
    .bank_q  (bank_q),
    .ctrl_q  (ctrl_q)
  );

  // A13 set folds $2xxx and $3xxx onto the four nametable windows
  assign win = ppu_a_hi[3] ? {2'b10, ppu_a_hi[1:0]} : {1'b0, ppu_a_hi[2:0]};

  ppu_win_router u_router (
    .win   (win),
    .mode  (ctrl_q.mode),
    .arr_lo(ctrl_q.arr_lo),
    .sel   (sel),
    .dbl   (dbl),
    .is_nt (is_nt)
  );

  assign bank_raw = bank_q[sel];

  ppu_lsb_patch u_lsb (
    .ctrl   (ctrl_q),
    .is_nt  (is_nt),
    .dbl    (dbl),
    .a10    (ppu_a_hi[0]),
    .a11    (ppu_a_hi[1]),
    .reg_lsb(bank_raw[0]),
    .lsb    (lsb)
  );

  assign chr_bank   = {bank_raw[BANK_W-1:1], lsb};
  assign rom_en     = !is_nt || ctrl_q.nt_rom;
  assign ciram_en   = is_nt && !ctrl_q.nt_rom;
  assign ciram_a10  = ciram_en & lsb;
  assign prg_ram_en = ctrl_q.prg_ram_on && (cpu_addr[CPU_AW-1 -: 3] == PRG_WIN_TAG);

endmodule

// File: rtl/ppu_bank_mapper_chk.sv
module ppu_bank_mapper_chk
  import ppu_bank_pkg::*;
#(
  parameter int                CPU_AW      = 16,
  parameter int                BANK_W      = 8,
  parameter logic [CPU_AW-1:0] CTRL_ADDR   = 16'hB003,
  parameter logic [2:0]        PRG_WIN_TAG = 3'b011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [BANK_W-1:0] wr_data,
  input ctrl_t             ctrl_q,
  input logic [3:0]        ppu_a_hi,
  input logic              rom_en,
  input logic              ciram_en,
  input logic              prg_ram_en
);

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cpu_addr == CTRL_ADDR) |=> (ctrl_q == ctrl_t'($past(wr_data[7:0])))); // R2

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_en, ciram_en}) == 1); // R6

  AST_PATTERN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_a_hi[3] |-> (rom_en && !ciram_en)); // R6

  AST_NT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_a_hi[3] |-> (ciram_en == !ctrl_q.nt_rom)); // R6

  AST_PRG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ram_en |-> (ctrl_q.prg_ram_on && cpu_addr[CPU_AW-1 -: 3] == PRG_WIN_TAG)); // R11

endmodule

bind ppu_bank_mapper ppu_bank_mapper_chk #(
  .CPU_AW     (CPU_AW),
  .BANK_W     (BANK_W),
  .CTRL_ADDR  (CTRL_ADDR),
  .PRG_WIN_TAG(PRG_WIN_TAG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .cpu_addr  (cpu_addr),
  .wr_data   (wr_data),
  .ctrl_q    (ctrl_q),
  .ppu_a_hi  (ppu_a_hi),
  .rom_en    (rom_en),
  .ciram_en  (ciram_en),
  .prg_ram_en(prg_ram_en)
);

// File: tb/ppu_bank_mapper_tb.sv
module ppu_bank_mapper_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [3:0]  ppu_a_hi = 4'h0;
  logic [7:0]  chr_bank;
  logic        rom_en, ciram_en, ciram_a10, prg_ram_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppu_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .cpu_addr(cpu_addr), .wr_data(wr_data), .ppu_a_hi(ppu_a_hi),
    .chr_bank(chr_bank), .rom_en(rom_en), .ciram_en(ciram_en),
    .ciram_a10(ciram_a10), .prg_ram_en(prg_ram_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    cpu_addr = 16'h0000;
  endtask

  // expected byte: bit7 = ROM, bit6 = internal RAM, bits 5:0 = bank
  task automatic check_row(input string req, input logic [7:0] ctrl, input logic [7:0] e [12]);
    cpu_write(16'hB003, ctrl);
    for (int w = 0; w < 12; w++) begin
      logic [7:0] eb;
      logic       er;
      ppu_a_hi = (w < 8) ? {1'b0, 3'(w)} : {2'b10, 2'(w - 8)};
      #1;
      eb = {2'b00, e[w][5:0]};
      er = e[w][7];
      check(req, $sformatf("ctrl=%02h win=%0d bank", ctrl, w), int'(chr_bank), int'(eb));
      check(req, $sformatf("ctrl=%02h win=%0d rom", ctrl, w), int'(rom_en), int'(er));
      check(req, $sformatf("ctrl=%02h win=%0d ciram", ctrl, w), int'(ciram_en), int'(!er));
      check("R7", $sformatf("ctrl=%02h win=%0d ciram_a10", ctrl, w), int'(ciram_a10),
            int'(!er && eb[0]));
    end
  endtask

  task automatic t_reset_r1();
    cpu_addr = 16'h6000;
    ppu_a_hi = 4'h0;
    #1;
    check("R1", "win0 bank", int'(chr_bank), 0);
    check("R1", "win0 rom", int'(rom_en), 1);
    check("R1", "prg_ram_en", int'(prg_ram_en), 0);
    ppu_a_hi = 4'h8;
    #1;
    check("R1", "win8 bank", int'(chr_bank), 0);
    check("R1", "win8 ciram", int'(ciram_en), 1);
    check("R2", "wr_ready", int'(wr_ready), 1);
    cpu_addr = 16'h0000;
  endtask

  task automatic t_load_r2();
    cpu_write(16'hD000, 8'h01); cpu_write(16'hD001, 8'h08);
    cpu_write(16'hD002, 8'h10); cpu_write(16'hD003, 8'h19);
    cpu_write(16'hE000, 8'h20); cpu_write(16'hE001, 8'h29);
    cpu_write(16'hE002, 8'h31); cpu_write(16'hE003, 8'h38);
    check_row("R2", 8'h00, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h71,8'h71,8'h78,8'h78});
    cpu_write(16'hD004, 8'hFF); cpu_write(16'hE004, 8'hFF);
    cpu_write(16'hC000, 8'hFF); cpu_write(16'hB002, 8'hFF);
    cpu_write(16'hF003, 8'hFF);
    check_row("R2", 8'h00, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h71,8'h71,8'h78,8'h78});
  endtask

  task automatic t_mode0_r3();
    check_row("R3", 8'h04, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h71,8'h78,8'h71,8'h78});
  endtask

  task automatic t_mode1_r4();
    check_row("R4", 8'h01, '{8'h81,8'h81,8'h88,8'h88,8'h90,8'h90,8'h99,8'h99,8'h60,8'h69,8'h71,8'h78});
    check_row("R4", 8'h05, '{8'h81,8'h81,8'h88,8'h88,8'h90,8'h90,8'h99,8'h99,8'h60,8'h69,8'h71,8'h78});
  endtask

  task automatic t_mode23_r5();
    check_row("R5", 8'h02, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA0,8'hA9,8'hA9,8'h71,8'h78,8'h71,8'h78});
    check_row("R5", 8'h07, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA0,8'hA9,8'hA9,8'h71,8'h71,8'h78,8'h78});
  endtask

  task automatic t_rom_nt_r6();
    check_row("R6", 8'h13, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA0,8'hA9,8'hA9,8'hB1,8'hB8,8'hB1,8'hB8});
    check_row("R6", 8'h11, '{8'h81,8'h81,8'h88,8'h88,8'h90,8'h90,8'h99,8'h99,8'hA0,8'hA9,8'hB1,8'hB8});
  endtask

  task automatic t_pat_sub_r8();
    check_row("R8", 8'h21, '{8'h80,8'h81,8'h88,8'h89,8'h90,8'h91,8'h98,8'h99,8'h60,8'h69,8'h71,8'h78});
    check_row("R8", 8'h22, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA1,8'hA8,8'hA9,8'h71,8'h78,8'h71,8'h78});
  endtask

  task automatic t_nt_sub_r9();
    check_row("R9", 8'h20, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h70,8'h71,8'h78,8'h79});
    check_row("R9", 8'h23, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA1,8'hA8,8'hA9,8'h70,8'h78,8'h71,8'h79});
    check_row("R9", 8'h28, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h70,8'h70,8'h78,8'h78});
    check_row("R9", 8'h2C, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA9,8'hB1,8'hB8,8'h71,8'h79,8'h71,8'h79});
    check_row("R9", 8'h3F, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA1,8'hA8,8'hA9,8'hB0,8'hB0,8'hB8,8'hB8});
    check_row("R9", 8'h2B, '{8'h81,8'h88,8'h90,8'h99,8'hA0,8'hA1,8'hA8,8'hA9,8'h71,8'h79,8'h71,8'h79});
    check_row("R9", 8'h25, '{8'h80,8'h81,8'h88,8'h89,8'h90,8'h91,8'h98,8'h99,8'h60,8'h69,8'h71,8'h78});
  endtask

  task automatic t_mirror_r10();
    cpu_write(16'hB003, 8'h24);
    for (int n = 0; n < 4; n++) begin
      logic [7:0] ref_bank;
      logic       ref_ci, ref_a10;
      ppu_a_hi = {2'b10, 2'(n)};
      #1;
      ref_bank = chr_bank; ref_ci = ciram_en; ref_a10 = ciram_a10;
      ppu_a_hi = {2'b11, 2'(n)};
      #1;
      check("R10", $sformatf("mirror %0d bank", n), int'(chr_bank), int'(ref_bank));
      check("R10", $sformatf("mirror %0d ciram", n), int'(ciram_en), int'(ref_ci));
      check("R10", $sformatf("mirror %0d a10", n), int'(ciram_a10), int'(ref_a10));
    end
    ppu_a_hi = 4'hD;
    #1;
    check("R10", "$3400 bank", int'(chr_bank), 8'h38);
  endtask

  task automatic t_prg_r11();
    cpu_write(16'hB003, 8'h80);
    cpu_addr = 16'h6000; #1; check("R11", "on $6000", int'(prg_ram_en), 1);
    cpu_addr = 16'h7FFF; #1; check("R11", "on $7FFF", int'(prg_ram_en), 1);
    cpu_addr = 16'h5FFF; #1; check("R11", "on $5FFF", int'(prg_ram_en), 0);
    cpu_addr = 16'h8000; #1; check("R11", "on $8000", int'(prg_ram_en), 0);
    cpu_write(16'hB003, 8'h7F);
    cpu_addr = 16'h6000; #1; check("R11", "off $6000", int'(prg_ram_en), 0);
    cpu_addr = 16'h0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_load_r2();
    t_mode0_r3();
    t_mode1_r4();
    t_mode23_r5();
    t_rom_nt_r6();
    t_pat_sub_r8();
    t_nt_sub_r9();
    t_mirror_r10();
    t_prg_r11();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule